// File: doc/BRIEF.md
# Sixteen-Line Transmit Fetch Scheduler

This block is the output side of a serial line multiplexer. Software picks a line through a selector field in the control word. It then loads that line's memory pointer, a byte counter that holds the negative of the byte total, and a line format word. Setting the line's bit in the run bitmap starts the line. The scheduler moves bytes from memory to each line's serializer until the counter climbs to zero. It then drops the run bit and raises a completion flag that can drive an interrupt.

Memory is read through a single-outstanding request/acknowledge port that returns one byte per request. A line is only considered for a fetch while its serializer reports ready. Ready lines take turns in rotating order, one fetch per turn. An error response from memory cancels the line in flight and records a memory-fault flag. A separate per-line break bitmap forces the line outputs to spacing, and each line's format word is presented to its serializer.

Software interface: a write strobe with a 3-bit register index and 16-bit data, plus a combinational read-back. The index values are: 0 control, 1 line format, 2 pointer low 16 bits, 3 byte counter, 4 run bitmap, 5 break bitmap.

Top module: `mux_tx_dma`

## Requirements
- R1: Control bits 3:0 choose the line that indexes 1, 2 and 3 reach. Bits 5:4 of a control write load memory address bits 17:16 of the line named in that same write, and they read back for the chosen line.
- R2: The byte counter holds a two's-complement negative total and rises by one per delivered byte. A line started with counter -N delivers exactly N bytes and then reads 0.
- R3: Writing index 4 sets each run bit written as 1; a 0 has no effect. Hardware clears the bit when the line completes. A line started with counter 0 completes without any fetch.
- R4: The pointer advances by one per byte fetched and reads back the address following the last byte delivered.
- R5: Writing -1 to the counter of a started line stops it after exactly one more byte, and it then completes normally.
- R6: Control bit 15 sets whenever a line completes, and bit 13 enables it. The irq output is high only while both are set. A control write with bit 15 at 0 clears the flag, and a write with bit 15 at 1 leaves it.
- R7: A memory error response aborts the line in flight and clears its run bit. It delivers no byte, sets control bit 10, and does not set bit 15. A control write with bit 8 at 1 clears bit 10.
- R8: Index 5 holds one break bit per line. brk_out follows it, and it reads back.
- R9: Index 1 stores 15 format bits for the chosen line, and line_cfg presents them at bits [15*k +: 15] for line k. Bits 1:0 give character length (01=6, 10=7, 11=8). Bit 2 gives two stop bits, bit 4 parity enable and bit 5 odd parity. Bits 9:6 give the receive rate code, bits 13:10 the send rate code, and bit 14 half duplex.
- R10: Running lines with ready serializers are served in rotating order, one fetch per grant, so two competing lines alternate byte by byte.
- R11: A fetch is issued for a line only while its ser_ready is high. Each fetched byte appears on ser_data with a one-cycle, one-hot ser_valid pulse on the cycle after the acknowledge.
- R12: At most one memory request is outstanding. mem_req stays high with a stable mem_addr until mem_ack or mem_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 18 | Memory byte address |
| mem_ack | input | 1 | Read data valid |
| mem_err | input | 1 | Non-existent memory response |
| mem_rdata | input | 8 | Read data byte |
| ser_ready | input | 16 | Per-line serializer can take a byte |
| ser_valid | output | 16 | Per-line byte strobe |
| ser_data | output | 8 | Byte for the strobed line |
| line_cfg | output | 240 | Per-line 15-bit format words |
| brk_out | output | 16 | Per-line force-spacing |
| irq | output | 1 | Completion interrupt |

## Verification
On every cycle, the bound checker holds the memory handshake steady and keeps byte strobes one-hot and tied to an acknowledge. It also confirms that a request only starts for a running line whose serializer was ready, that a run bit dropped without an error always leaves the completion flag set, and that an error response always leaves the fault flag set. Counted transfer lengths, pointer read-back, the one-extra-byte stop, alternation between competing lines, the address extension and the effect of the clear bits depend on multi-cycle scenarios. Only the directed bench tasks show these.

// File: rtl/txm_pkg.sv
package txm_pkg;
   localparam int WORD_W = 16;
   localparam int LPAR_W = 15;

   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_LPAR  = 3'd1,
      RA_CADDR = 3'd2,
      RA_BCNT  = 3'd3,
      RA_ACTV  = 3'd4,
      RA_BRK   = 3'd5
   } reg_idx_e;

   // control word bit positions
   localparam int CB_EXT_LO  = 4;
   localparam int CB_NXM_CLR = 8;
   localparam int CB_NXM     = 10;
   localparam int CB_TIE     = 13;
   localparam int CB_TI      = 15;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fetch_st_e;
endpackage

// File: rtl/txm_line_bank.sv
module txm_line_bank
   import txm_pkg::*;
#(
   parameter int NLINES = 16,
   parameter int EXT_W  = 2,
   localparam int AW    = WORD_W + EXT_W,
   localparam int SELW  = $clog2(NLINES)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SELW-1:0]          sel,
   input  logic [WORD_W-1:0]        wdata,
   input  logic                     we_lo,
   input  logic                     we_ext,
   input  logic [EXT_W-1:0]         ext_data,
   input  logic                     we_cnt,
   input  logic                     we_par,
   input  logic                     adv,
   input  logic [SELW-1:0]          adv_line,
   output logic [NLINES*AW-1:0]     addr_flat,
   output logic [NLINES*WORD_W-1:0] cnt_flat,
   output logic [NLINES*LPAR_W-1:0] par_flat
);
   for (genvar g = 0; g < NLINES; g++) begin : g_line
      logic [AW-1:0]     a_q, a_base;
      logic [WORD_W-1:0] c_q, c_base;
      logic [LPAR_W-1:0] p_q;
      logic              hit, bump;

      assign hit  = (sel == SELW'(g));
      assign bump = adv && (adv_line == SELW'(g));

      // software write lands first, a same-cycle byte then adds on top
      always_comb begin
         a_base = a_q;
         if (we_lo && hit)  a_base[WORD_W-1:0]  = wdata;
         if (we_ext && hit) a_base[AW-1:WORD_W] = ext_data;
         c_base = (we_cnt && hit) ? wdata : c_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            c_q <= '0;
            p_q <= '0;
         end else begin
            a_q <= a_base + AW'(bump);
            c_q <= c_base + WORD_W'(bump);
            if (we_par && hit) p_q <= wdata[LPAR_W-1:0];
         end
      end

      assign addr_flat[g*AW +: AW]         = a_q;
      assign cnt_flat[g*WORD_W +: WORD_W]  = c_q;
      assign par_flat[g*LPAR_W +: LPAR_W]  = p_q;
   end
endmodule

// File: rtl/txm_rr_arb.sv
module txm_rr_arb #(
   parameter int NLINES  = 16,
   parameter bit RR_FAIR = 1'b1,
   localparam int SELW   = $clog2(NLINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] req,
   input  logic              take,
   output logic              gnt_any,
   output logic [SELW-1:0]   gnt_idx
);
   if (RR_FAIR) begin : g_rotate
      logic [SELW-1:0] last_q;

      always_comb begin
         gnt_any = 1'b0;
         gnt_idx = '0;
         for (int i = 1; i <= NLINES; i++) begin
            int k;
            k = (int'(last_q) + i) % NLINES;
            if (!gnt_any && req[k]) begin
               gnt_any = 1'b1;
               gnt_idx = SELW'(k);
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    last_q <= SELW'(NLINES - 1);
         else if (take) last_q <= gnt_idx;
      end
   end else begin : g_fixed
      always_comb begin
         gnt_any = 1'b0;
         gnt_idx = '0;
         for (int i = NLINES - 1; i >= 0; i--) begin
            if (req[i]) begin
               gnt_any = 1'b1;
               gnt_idx = SELW'(i);
            end
         end
      end
   end
endmodule

// File: rtl/txm_fetch.sv
module txm_fetch
   import txm_pkg::*;
#(
   parameter int NLINES = 16,
   parameter int AW     = 18,
   localparam int SELW  = $clog2(NLINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gnt_any,
   input  logic [SELW-1:0]   gnt_idx,
   input  logic [AW-1:0]     gnt_addr,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [7:0]        mem_rdata,
   output logic              take,
   output logic              busy,
   output logic [SELW-1:0]   cur_idx,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   output logic              done,
   output logic              abort,
   output logic [NLINES-1:0] ser_valid,
   output logic [7:0]        ser_data
);
   fetch_st_e         st_q;
   logic [SELW-1:0]   cur_q;
   logic [AW-1:0]     addr_q;
   logic [NLINES-1:0] sv_q;
   logic [7:0]        sd_q;

   assign busy     = (st_q == FS_WAIT);
   assign mem_req  = busy;
   assign mem_addr = addr_q;
   assign cur_idx  = cur_q;
   assign take     = !busy && gnt_any;
   assign done     = busy && mem_ack && !mem_err;
   assign abort    = busy && mem_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_IDLE;
         cur_q  <= '0;
         addr_q <= '0;
         sv_q   <= '0;
         sd_q   <= '0;
      end else begin
         if (take) begin
            st_q   <= FS_WAIT;
            cur_q  <= gnt_idx;
            addr_q <= gnt_addr;
         end else if (busy && (mem_ack || mem_err)) begin
            st_q <= FS_IDLE;
         end
         sv_q <= done ? (NLINES'(1) << cur_q) : '0;
         if (done) sd_q <= mem_rdata;
      end
   end

   assign ser_valid = sv_q;
   assign ser_data  = sd_q;
endmodule

// File: rtl/mux_tx_dma.sv
module mux_tx_dma
   import txm_pkg::*;
#(
   parameter int NLINES  = 16,
   parameter int EXT_W   = 2,
   parameter bit RR_FAIR = 1'b1,
   localparam int AW     = WORD_W + EXT_W,
   localparam int SELW   = $clog2(NLINES)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [2:0]               reg_addr,
   input  logic [WORD_W-1:0]        reg_wdata,
   output logic [WORD_W-1:0]        reg_rdata,
   output logic                     mem_req,
   output logic [AW-1:0]            mem_addr,
   input  logic                     mem_ack,
   input  logic                     mem_err,
   input  logic [7:0]               mem_rdata,
   input  logic [NLINES-1:0]        ser_ready,
   output logic [NLINES-1:0]        ser_valid,
   output logic [7:0]               ser_data,
   output logic [NLINES*LPAR_W-1:0] line_cfg,
   output logic [NLINES-1:0]        brk_out,
   output logic                     irq
);
   if (NLINES < 2 || NLINES > 16) begin : g_bad_nlines
      $error("NLINES must lie in 2..16 to fit the selector field");
   end
   if (EXT_W < 1 || EXT_W > 2) begin : g_bad_ext
      $error("EXT_W must be 1 or 2 to fit control bits 5:4");
   end

   logic [SELW-1:0]          sel_q;
   logic                     tie_q, ti_q, nxm_q;
   logic [NLINES-1:0]        actv_q, brk_q;
   logic                     wr_ctrl, wr_lpar, wr_caddr, wr_bcnt, wr_actv, wr_brk;
   logic [SELW-1:0]          bank_sel;
   logic [NLINES*AW-1:0]     addr_flat;
   logic [NLINES*WORD_W-1:0] cnt_flat;
   logic [NLINES*LPAR_W-1:0] par_flat;
   logic [NLINES-1:0]        zero_m, req_v, cur_oh, retire_v, abort_v;
   logic                     gnt_any, take, busy, done, abort;
   logic [SELW-1:0]          gnt_idx, cur_idx;
   logic [AW-1:0]            sel_addr;

   assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
   assign wr_lpar  = reg_wr && (reg_addr == RA_LPAR);
   assign wr_caddr = reg_wr && (reg_addr == RA_CADDR);
   assign wr_bcnt  = reg_wr && (reg_addr == RA_BCNT);
   assign wr_actv  = reg_wr && (reg_addr == RA_ACTV);
   assign wr_brk   = reg_wr && (reg_addr == RA_BRK);

   // a control write steers its address-extension bits to the newly named line
   assign bank_sel = wr_ctrl ? reg_wdata[SELW-1:0] : sel_q;

   txm_line_bank #(.NLINES(NLINES), .EXT_W(EXT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bank_sel),
      .wdata    (reg_wdata),
      .we_lo    (wr_caddr),
      .we_ext   (wr_ctrl),
      .ext_data (reg_wdata[CB_EXT_LO +: EXT_W]),
      .we_cnt   (wr_bcnt),
      .we_par   (wr_lpar),
      .adv      (done),
      .adv_line (cur_idx),
      .addr_flat(addr_flat),
      .cnt_flat (cnt_flat),
      .par_flat (par_flat)
   );

   for (genvar g = 0; g < NLINES; g++) begin : g_zero
      assign zero_m[g] = (cnt_flat[g*WORD_W +: WORD_W] == '0);
   end

   assign req_v    = actv_q & ser_ready & ~zero_m;
   assign cur_oh   = busy  ? (NLINES'(1) << cur_idx) : '0;
   assign abort_v  = abort ? (NLINES'(1) << cur_idx) : '0;
   assign retire_v = actv_q & zero_m & ~cur_oh;

   txm_rr_arb #(.NLINES(NLINES), .RR_FAIR(RR_FAIR)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_v),
      .take   (take),
      .gnt_any(gnt_any),
      .gnt_idx(gnt_idx)
   );

   txm_fetch #(.NLINES(NLINES), .AW(AW)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt_any  (gnt_any),
      .gnt_idx  (gnt_idx),
      .gnt_addr (addr_flat[gnt_idx*AW +: AW]),
      .mem_ack  (mem_ack),
      .mem_err  (mem_err),
      .mem_rdata(mem_rdata),
      .take     (take),
      .busy     (busy),
      .cur_idx  (cur_idx),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .done     (done),
      .abort    (abort),
      .ser_valid(ser_valid),
      .ser_data (ser_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         tie_q  <= 1'b0;
         ti_q   <= 1'b0;
         nxm_q  <= 1'b0;
         actv_q <= '0;
         brk_q  <= '0;
      end else begin
         actv_q <= (actv_q & ~retire_v & ~abort_v)
                 | (wr_actv ? reg_wdata[NLINES-1:0] : '0);
         if (wr_brk) brk_q <= reg_wdata[NLINES-1:0];
         if (wr_ctrl) begin
            sel_q <= reg_wdata[SELW-1:0];
            tie_q <= reg_wdata[CB_TIE];
         end
         if (|retire_v)                        ti_q <= 1'b1;
         else if (wr_ctrl && !reg_wdata[CB_TI]) ti_q <= 1'b0;
         if (abort)                                 nxm_q <= 1'b1;
         else if (wr_ctrl && reg_wdata[CB_NXM_CLR]) nxm_q <= 1'b0;
      end
   end

   assign sel_addr = addr_flat[sel_q*AW +: AW];

   always_comb begin
      reg_rdata = '0;
      case (reg_idx_e'(reg_addr))
         RA_CTRL: begin
            reg_rdata[SELW-1:0]          = sel_q;
            reg_rdata[CB_EXT_LO +: EXT_W] = sel_addr[AW-1:WORD_W];
            reg_rdata[CB_NXM]            = nxm_q;
            reg_rdata[CB_TIE]            = tie_q;
            reg_rdata[CB_TI]             = ti_q;
         end
         RA_LPAR:  reg_rdata[LPAR_W-1:0] = par_flat[sel_q*LPAR_W +: LPAR_W];
         RA_CADDR: reg_rdata = sel_addr[WORD_W-1:0];
         RA_BCNT:  reg_rdata = cnt_flat[sel_q*WORD_W +: WORD_W];
         RA_ACTV:  reg_rdata[NLINES-1:0] = actv_q;
         RA_BRK:   reg_rdata[NLINES-1:0] = brk_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign line_cfg = par_flat;
   assign brk_out  = brk_q;
   assign irq      = ti_q & tie_q;
endmodule

// File: rtl/mux_tx_dma_chk.sv
module mux_tx_dma_chk #(
   parameter int NLINES = 16,
   parameter int AW     = 18,
   localparam int SELW  = $clog2(NLINES)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_err,
   input logic [AW-1:0]     mem_addr,
   input logic [NLINES-1:0] ser_valid,
   input logic [NLINES-1:0] ser_ready,
   input logic [NLINES-1:0] actv,
   input logic [SELW-1:0]   cur_idx,
   input logic              ti,
   input logic              nxm
);
   logic [NLINES-1:0] ready_d;
   always_ff @(posedge clk) ready_d <= ser_ready;

   // R12: request held with stable address until answered
   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr));

   // R11: strobes are one-hot
   p_valid_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ser_valid));

   // R11: a strobe only follows a clean acknowledge
   p_valid_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|ser_valid) |-> $past(mem_req && mem_ack && !mem_err));

   // R11: a request starts only for a line whose serializer was ready
   p_issue_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> ready_d[cur_idx]);

   // R3: a request starts only for a running line
   p_issue_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> actv[cur_idx]);

   // R6: a run bit cleared without an error leaves the completion flag set
   p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(actv) & ~actv)) && !$past(mem_req && mem_err) |-> ti);

   // R7: an error response sets the fault flag
   p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_err |=> nxm);
endmodule

bind mux_tx_dma mux_tx_dma_chk #(.NLINES(NLINES), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_req  (mem_req),
   .mem_ack  (mem_ack),
   .mem_err  (mem_err),
   .mem_addr (mem_addr),
   .ser_valid(ser_valid),
   .ser_ready(ser_ready),
   .actv     (actv_q),
   .cur_idx  (cur_idx),
   .ti       (ti_q),
   .nxm      (nxm_q)
);

// File: tb/mux_tx_dma_tb_top.sv
module mux_tx_dma_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NL  = 16;
   localparam int AWB = 18;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [2:0]        reg_addr = 3'd0;
   logic [15:0]       reg_wdata = 16'd0;
   logic [15:0]       reg_rdata;
   logic              mem_req;
   logic [AWB-1:0]    mem_addr;
   logic              mem_ack = 1'b0;
   logic              mem_err = 1'b0;
   logic [7:0]        mem_rdata = 8'd0;
   logic [NL-1:0]     ser_ready = '1;
   logic [NL-1:0]     ser_valid;
   logic [7:0]        ser_data;
   logic [NL*15-1:0]  line_cfg;
   logic [NL-1:0]     brk_out;
   logic              irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_tx_dma dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
      .mem_rdata(mem_rdata), .ser_ready(ser_ready), .ser_valid(ser_valid),
      .ser_data(ser_data), .line_cfg(line_cfg), .brk_out(brk_out), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   int byte_cnt[NL];
   logic [7:0] last_byte[NL];
   int seq[64];
   int seq_n = 0;
   int req_cyc = 0;

   function automatic logic [7:0] mem_fn(input logic [AWB-1:0] a);
      return a[7:0] ^ {a[17:16], 6'b0};
   endfunction

   // memory model: errors in the top quarter of the space
   always @(negedge clk) begin
      if (mem_ack || mem_err) begin
         mem_ack = 1'b0;
         mem_err = 1'b0;
      end else if (mem_req) begin
         if (mem_addr[17:16] == 2'd3) mem_err = 1'b1;
         else begin
            mem_ack   = 1'b1;
            mem_rdata = mem_fn(mem_addr);
         end
      end
   end

   // serializer-side monitor
   always @(negedge clk) begin
      if (mem_req) req_cyc++;
      for (int l = 0; l < NL; l++) begin
         if (ser_valid[l]) begin
            byte_cnt[l]++;
            last_byte[l] = ser_data;
            if (seq_n < 64) begin
               seq[seq_n] = l;
               seq_n++;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // select line, keep completion flag, interrupt enabled
   task automatic pick(input int line, input logic [1:0] ext);
      wr(3'd0, 16'hA000 | (16'(ext) << 4) | 16'(line));
   endtask

   task automatic setup_line(input int line, input logic [1:0] ext,
                             input logic [15:0] a, input logic [15:0] c);
      pick(line, ext);
      wr(3'd2, a);
      wr(3'd3, c);
   endtask

   task automatic wait_idle(input logic [15:0] mask, input string tag);
      logic [15:0] d;
      int k;
      for (k = 0; k < 3000; k++) begin
         rd(3'd4, d);
         if ((d & mask) == 16'd0) break;
      end
      chk({tag, " run bits clear"}, 32'(d & mask), 32'd0);
   endtask

   task automatic clr_counts();
      for (int l = 0; l < NL; l++) byte_cnt[l] = 0;
      seq_n = 0;
      req_cyc = 0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      rd(3'd0, d); chk("R6 reset control", 32'(d), 32'd0);
      rd(3'd4, d); chk("R3 reset run bitmap", 32'(d), 32'd0);
      chk("R12 reset mem_req", 32'(mem_req), 32'd0);
      chk("R6 reset irq", 32'(irq), 32'd0);
   endtask

   task automatic t_single();
      logic [15:0] d;
      clr_counts();
      setup_line(3, 2'd0, 16'h0100, 16'hFFFC);
      wr(3'd4, 16'h0008);
      wait_idle(16'h0008, "R3 single");
      chk("R2 four bytes", 32'(byte_cnt[3]), 32'd4);
      chk("R11 last byte", 32'(last_byte[3]), 32'(mem_fn(18'h00103)));
      rd(3'd2, d); chk("R4 pointer advanced", 32'(d), 32'h0104);
      rd(3'd3, d); chk("R2 counter zero", 32'(d), 32'd0);
      rd(3'd0, d); chk("R6 flag set", 32'(d[15]), 32'd1);
      chk("R6 irq high", 32'(irq), 32'd1);
   endtask

   task automatic t_flag_clear();
      logic [15:0] d;
      wr(3'd0, 16'h2003);
      rd(3'd0, d); chk("R6 flag cleared", 32'(d[15]), 32'd0);
      chk("R6 irq low", 32'(irq), 32'd0);
   endtask

   task automatic t_ext();
      logic [15:0] d;
      clr_counts();
      setup_line(5, 2'd2, 16'h0010, 16'hFFFE);
      rd(3'd0, d); chk("R1 ext read back", 32'(d[5:4]), 32'd2);
      chk("R1 selector read back", 32'(d[3:0]), 32'd5);
      wr(3'd4, 16'h0020);
      wait_idle(16'h0020, "R1 ext");
      chk("R1 byte from high bank", 32'(last_byte[5]), 32'(mem_fn(18'h20011)));
      chk("R2 two bytes", 32'(byte_cnt[5]), 32'd2);
   endtask

   task automatic t_rr();
      int alt;
      clr_counts();
      setup_line(1, 2'd0, 16'h0300, 16'hFFFD);
      setup_line(2, 2'd0, 16'h0400, 16'hFFFD);
      wr(3'd4, 16'h0006);
      wait_idle(16'h0006, "R10 pair");
      chk("R10 total bytes", 32'(seq_n), 32'd6);
      alt = 0;
      for (int i = 1; i < 6; i++) if (seq[i] != seq[i-1]) alt++;
      chk("R10 alternation", 32'(alt), 32'd5);
      chk("R10 line1 bytes", 32'(byte_cnt[1]), 32'd3);
      chk("R10 line2 bytes", 32'(byte_cnt[2]), 32'd3);
   endtask

   task automatic t_ready();
      logic [15:0] d;
      clr_counts();
      ser_ready[7] = 1'b0;
      setup_line(7, 2'd0, 16'h0500, 16'hFFFE);
      wr(3'd4, 16'h0080);
      repeat (20) @(negedge clk);
      chk("R11 no request while not ready", 32'(req_cyc), 32'd0);
      chk("R11 no byte while not ready", 32'(byte_cnt[7]), 32'd0);
      rd(3'd4, d); chk("R11 still running", 32'(d[7]), 32'd1);
      ser_ready[7] = 1'b1;
      wait_idle(16'h0080, "R11 ready");
      chk("R11 bytes after ready", 32'(byte_cnt[7]), 32'd2);
   endtask

   task automatic t_stop();
      logic [15:0] d;
      int n0;
      clr_counts();
      setup_line(4, 2'd0, 16'h0200, 16'hFF9C);
      wr(3'd4, 16'h0010);
      repeat (10) @(negedge clk);
      ser_ready[4] = 1'b0;
      repeat (4) @(negedge clk);
      n0 = byte_cnt[4];
      wr(3'd3, 16'hFFFF);
      ser_ready[4] = 1'b1;
      wait_idle(16'h0010, "R5 stop");
      chk("R5 one byte after stop", 32'(byte_cnt[4]), 32'(n0 + 1));
      rd(3'd2, d); chk("R4 pointer after stop", 32'(d), 32'(16'h0200 + n0 + 1));
      rd(3'd3, d); chk("R5 counter zero", 32'(d), 32'd0);
   endtask

   task automatic t_nxm();
      logic [15:0] d;
      clr_counts();
      wr(3'd0, 16'h2000);
      setup_line(9, 2'd3, 16'h0000, 16'hFFFE);
      wr(3'd4, 16'h0200);
      wait_idle(16'h0200, "R7 abort");
      chk("R7 no byte", 32'(byte_cnt[9]), 32'd0);
      rd(3'd0, d);
      chk("R7 fault bit", 32'(d[10]), 32'd1);
      chk("R7 no completion flag", 32'(d[15]), 32'd0);
      wr(3'd0, 16'h2109);
      rd(3'd0, d); chk("R7 fault cleared", 32'(d[10]), 32'd0);
   endtask

   task automatic t_break();
      logic [15:0] d;
      wr(3'd5, 16'h8001);
      chk("R8 break out", 32'(brk_out), 32'h8001);
      rd(3'd5, d); chk("R8 break read", 32'(d), 32'h8001);
      wr(3'd5, 16'h0000);
      chk("R8 break off", 32'(brk_out), 32'd0);
   endtask

   task automatic t_params();
      logic [15:0] d;
      pick(6, 2'd0);
      wr(3'd1, 16'h4C7B);
      chk("R9 line6 cfg", 32'(line_cfg[6*15 +: 15]), 32'h4C7B);
      chk("R9 char length field", 32'(line_cfg[6*15 +: 2]), 32'd3);
      rd(3'd1, d); chk("R9 read back", 32'(d), 32'h4C7B);
      pick(2, 2'd0);
      rd(3'd1, d); chk("R9 other line untouched", 32'(d), 32'd0);
   endtask

   task automatic t_zero();
      logic [15:0] d;
      clr_counts();
      wr(3'd0, 16'h2000);
      setup_line(0, 2'd0, 16'h0600, 16'h0000);
      wr(3'd4, 16'h0001);
      repeat (3) @(negedge clk);
      rd(3'd4, d); chk("R3 zero count retires", 32'(d[0]), 32'd0);
      chk("R3 zero count no fetch", 32'(req_cyc), 32'd0);
      rd(3'd0, d); chk("R6 flag on zero count", 32'(d[15]), 32'd1);
      wr(3'd0, 16'h8000);
      chk("R6 irq masked", 32'(irq), 32'd0);
      rd(3'd0, d); chk("R6 flag kept by write of 1", 32'(d[15]), 32'd1);
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin
         byte_cnt[l] = 0;
         last_byte[l] = 8'd0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_flag_clear();
      t_ext();
      t_rr();
      t_ready();
      t_stop();
      t_nxm();
      t_break();
      t_params();
      t_zero();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule